// File: doc/BRIEF.md
# SDRAM Per-Bank Protocol Checker

This block sits beside an SDRAM command bus and only watches it. On every rising clock edge it decodes the clock-enable, chip-select, row/column strobes, write enable, bank address and the auto-precharge address bit. It keeps a model of every bank: idle, activating, row active, reading, writing, write recovering or precharging. It also tracks three device-wide conditions: the refresh window, the mode-register window and the first edge after a low-power exit. Any command that is illegal in the tracked state, or that arrives before a minimum delay has passed, produces a one-cycle error pulse and a code that names the violation class.

The model advances only on legal commands, so one bad command does not corrupt the checks that follow. All minimum delays are parameters counted in clock cycles and must each be at least 2. The block drives nothing onto the bus and does not look at data.

Top module: `sdram_chk`

## Requirements
- R1: While reset is asserted and on the first cycle after it, errPulse is 0 and errCode is 0, and every bank is idle.
- R2: A command is sampled at a rising edge when clock enable was high at the previous edge. Chip select high is a deselect and is treated like NOP. With chip select low, {rasN,casN,weN} encodes 000 mode set, 001 refresh, 010 precharge, 011 activate, 100 write, 101 read, 110 burst stop and 111 NOP. A violation at an edge sets errPulse to 1 and errCode to its code for exactly the following cycle. A legal command leaves both at 0.
- R3: A read or write addressed to a bank that is idle or precharging reports code 4.
- R4: An activate to a bank whose row is open (activating, active, reading, writing or recovering) reports code 5. An activate to a bank that is still inside T_RP after its precharge reports code 6. T_RP cycles after the precharge, the activate is legal.
- R5: A read or write to a bank fewer than T_RCD cycles after its activate reports code 7. At exactly T_RCD cycles it is legal.
- R6: A precharge fewer than T_RAS cycles after the activate reports code 8. The precharge is of one bank, or of all banks when a10 is 1. A precharge of an idle bank is legal and has no effect.
- R7: An activate fewer than T_RRD cycles after the previous accepted activate to any bank reports code 9.
- R8: A mode set, a refresh, or a clock-enable drop (power-down or self-refresh entry) while any bank is not idle reports code 3. With all banks idle these are legal.
- R9: For T_RC cycles after an accepted refresh, and for T_MRD cycles after an accepted mode set, any command other than NOP or deselect reports code 2.
- R10: While a bank runs a read or write with auto-precharge (a10 = 1), including the write recovery that follows, a read, write or precharge to it reports code 10. When the burst and recovery end, the bank precharges by itself.
- R11: A write burst lasts BURST_LEN cycles and is then followed by T_DPL cycles of write recovery. A precharge during that recovery reports code 11. Once recovery ends the bank is row active again.
- R12: At an edge where clock enable was low at the previous edge and is high now, any command other than NOP or deselect reports code 1. While clock enable stays low, commands are ignored.
- R13: A command that reports an error does not change any tracked state. When several violations apply to one command, the smallest code is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge samples |
| rstN | input | 1 | Active-low synchronous reset |
| cke | input | 1 | Clock enable as seen on the bus |
| csN | input | 1 | Chip select, active low |
| rasN | input | 1 | Row strobe, active low |
| casN | input | 1 | Column strobe, active low |
| weN | input | 1 | Write enable, active low |
| ba | input | $clog2(NUM_BANKS) | Bank address |
| a10 | input | 1 | Auto-precharge / all-bank flag |
| errPulse | output | 1 | One-cycle violation flag |
| errCode | output | 4 | Violation class, 0 when none |

## Verification
The bench builds the checker with four banks, T_RCD 3, T_RAS 5, T_RP 2, T_RRD 2, T_RC 6, T_MRD 2, T_DPL 2 and a burst length of 2. With these values every window closes within a few cycles. A single command stream can then probe each delay one cycle before it expires and again on the exact cycle it expires. The same short sequence carries a write with auto-precharge through its burst, recovery and self-timed precharge, and a plain write through its recovery. It also places overlapping violations on one command, which exercises the smallest-code rule.

// File: rtl/sdram_chk_pkg.sv
package sdram_chk_pkg;

  typedef enum logic [2:0] {
    BK_IDLE        = 3'd0,
    BK_ACTIVATING  = 3'd1,
    BK_ACTIVE      = 3'd2,
    BK_READING     = 3'd3,
    BK_WRITING     = 3'd4,
    BK_WRECOVER    = 3'd5,
    BK_PRECHARGING = 3'd6
  } bankState_t;

  // {rasN, casN, weN} with chip select low
  typedef enum logic [2:0] {
    CMD_MRS = 3'b000,
    CMD_REF = 3'b001,
    CMD_PRE = 3'b010,
    CMD_ACT = 3'b011,
    CMD_WR  = 3'b100,
    CMD_RD  = 3'b101,
    CMD_BST = 3'b110,
    CMD_NOP = 3'b111
  } busCmd_t;

  // Smaller value wins when several apply
  typedef enum logic [3:0] {
    ERR_NONE     = 4'd0,
    ERR_PD_EXIT  = 4'd1,
    ERR_DEV_BUSY = 4'd2,
    ERR_NOT_IDLE = 4'd3,
    ERR_NO_ROW   = 4'd4,
    ERR_ROW_OPEN = 4'd5,
    ERR_TRP      = 4'd6,
    ERR_TRCD     = 4'd7,
    ERR_TRAS     = 4'd8,
    ERR_TRRD     = 4'd9,
    ERR_AP_LOCK  = 4'd10,
    ERR_TDPL     = 4'd11
  } chkErr_t;

  // Control-to-datapath strobes, issued only for accepted commands
  typedef struct packed {
    logic act;
    logic rd;
    logic wr;
    logic pre;
    logic autoPre;
    logic loadRfsh;
    logic loadMrs;
  } chkStrobe_t;

endpackage

// File: rtl/sdram_chk_bank.sv
module sdram_chk_bank
  import sdram_chk_pkg::*;
#(
  parameter int T_RCD     = 3,
  parameter int T_RAS     = 7,
  parameter int T_RP      = 3,
  parameter int T_DPL     = 2,
  parameter int BURST_LEN = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       act,
  input  logic       rd,
  input  logic       wr,
  input  logic       pre,
  input  logic       autoPre,
  output bankState_t state,
  output logic       apFlag,
  output logic       rasPend
);

  localparam int MAX_A = (T_RCD > T_RAS) ? T_RCD : T_RAS;
  localparam int MAX_B = (T_RP > T_DPL) ? T_RP : T_DPL;
  localparam int MAX_C = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int MAXT  = (MAX_C > BURST_LEN) ? MAX_C : BURST_LEN;
  localparam int TW    = $clog2(MAXT + 1);

  logic [TW-1:0] tmr;
  logic [TW-1:0] rasTmr;
  logic          apReg;
  logic          tmrEnd;

  assign tmrEnd  = (tmr <= TW'(1));
  assign apFlag  = apReg;
  assign rasPend = (rasTmr != '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= BK_IDLE;
      tmr    <= '0;
      rasTmr <= '0;
      apReg  <= 1'b0;
    end else begin
      if (rasTmr != '0) rasTmr <= rasTmr - 1'b1;
      if (tmr != '0) tmr <= tmr - 1'b1;
      case (state)
        BK_IDLE: begin
          if (act) begin
            state  <= BK_ACTIVATING;
            tmr    <= TW'(T_RCD - 1);
            rasTmr <= TW'(T_RAS - 1);
          end
        end
        BK_ACTIVATING: if (tmrEnd) state <= BK_ACTIVE;
        BK_PRECHARGING: begin
          if (tmrEnd) begin
            state <= BK_IDLE;
            apReg <= 1'b0;
          end
        end
        default: begin
          if (pre) begin
            state <= BK_PRECHARGING;
            tmr   <= TW'(T_RP - 1);
            apReg <= 1'b0;
          end else if (rd) begin
            state <= BK_READING;
            tmr   <= TW'(BURST_LEN - 1);
            apReg <= autoPre;
          end else if (wr) begin
            state <= BK_WRITING;
            tmr   <= TW'(BURST_LEN - 1);
            apReg <= autoPre;
          end else if (tmrEnd) begin
            case (state)
              BK_READING, BK_WRECOVER: begin
                if (apReg) begin
                  state <= BK_PRECHARGING;
                  tmr   <= TW'(T_RP - 1);
                  apReg <= 1'b0;
                end else begin
                  state <= BK_ACTIVE;
                end
              end
              BK_WRITING: begin
                state <= BK_WRECOVER;
                tmr   <= TW'(T_DPL - 1);
              end
              default: ;
            endcase
          end
        end
      endcase
    end
  end

  // R4: an accepted activate only ever reaches an idle bank
  assert_act_on_idle_R4: assert property (@(posedge clk) disable iff (!rstN)
    act |-> (state == BK_IDLE));

  // R3 / R5: accepted column commands only reach a bank past its activate delay
  assert_col_on_open_R5: assert property (@(posedge clk) disable iff (!rstN)
    (rd || wr) |-> (state inside {BK_ACTIVE, BK_READING, BK_WRITING, BK_WRECOVER}));

  // R10: no accepted column command lands inside an auto-precharge burst
  assert_no_col_in_ap_R10: assert property (@(posedge clk) disable iff (!rstN)
    (rd || wr) |-> !apReg);

  // R6: an accepted precharge of an open row never cuts the row time short
  assert_pre_after_ras_R6: assert property (@(posedge clk) disable iff (!rstN)
    (pre && state != BK_IDLE && state != BK_PRECHARGING) |-> !rasPend);

  // R5: the activating state only ever moves on to row active
  assert_activating_exit_R5: assert property (@(posedge clk) disable iff (!rstN)
    (state == BK_ACTIVATING) |=> (state inside {BK_ACTIVATING, BK_ACTIVE}));

endmodule

// File: rtl/sdram_chk_banks.sv
module sdram_chk_banks
  import sdram_chk_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int T_RCD     = 3,
  parameter int T_RAS     = 7,
  parameter int T_RP      = 3,
  parameter int T_RRD     = 2,
  parameter int T_RC      = 9,
  parameter int T_MRD     = 2,
  parameter int T_DPL     = 2,
  parameter int BURST_LEN = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  chkStrobe_t           strb,
  input  logic [NUM_BANKS-1:0] bankSel,
  output logic [NUM_BANKS-1:0] idleVec,
  output logic [NUM_BANKS-1:0] actgVec,
  output logic [NUM_BANKS-1:0] prechVec,
  output logic [NUM_BANKS-1:0] wrecVec,
  output logic [NUM_BANKS-1:0] apVec,
  output logic [NUM_BANKS-1:0] rasPendVec,
  output logic                 rrdBusy,
  output logic                 devBusy
);

  localparam int DEV_MAX = (T_RC > T_MRD) ? T_RC : T_MRD;
  localparam int DW      = $clog2(DEV_MAX + 1);
  localparam int RW      = $clog2(T_RRD + 1);

  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
    bankState_t bankSt;
    logic       bankAp;
    sdram_chk_bank #(
      .T_RCD(T_RCD), .T_RAS(T_RAS), .T_RP(T_RP),
      .T_DPL(T_DPL), .BURST_LEN(BURST_LEN)
    ) u_bank (
      .clk    (clk),
      .rstN   (rstN),
      .act    (strb.act & bankSel[i]),
      .rd     (strb.rd  & bankSel[i]),
      .wr     (strb.wr  & bankSel[i]),
      .pre    (strb.pre & bankSel[i]),
      .autoPre(strb.autoPre),
      .state  (bankSt),
      .apFlag (bankAp),
      .rasPend(rasPendVec[i])
    );
    assign idleVec[i]  = (bankSt == BK_IDLE);
    assign actgVec[i]  = (bankSt == BK_ACTIVATING);
    assign prechVec[i] = (bankSt == BK_PRECHARGING);
    assign wrecVec[i]  = (bankSt == BK_WRECOVER);
    assign apVec[i]    = bankAp;
  end

  logic [RW-1:0] rrdTmr;
  logic [DW-1:0] devTmr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rrdTmr <= '0;
      devTmr <= '0;
    end else begin
      if (strb.act) rrdTmr <= RW'(T_RRD - 1);
      else if (rrdTmr != '0) rrdTmr <= rrdTmr - 1'b1;
      if (strb.loadRfsh) devTmr <= DW'(T_RC - 1);
      else if (strb.loadMrs) devTmr <= DW'(T_MRD - 1);
      else if (devTmr != '0) devTmr <= devTmr - 1'b1;
    end
  end

  assign rrdBusy = (rrdTmr != '0);
  assign devBusy = (devTmr != '0);

  // R7: no accepted activate while the bank-to-bank window is open
  assert_act_spacing_R7: assert property (@(posedge clk) disable iff (!rstN)
    strb.act |-> (rrdTmr == '0));

  // R9: the refresh / mode-set window accepts nothing
  assert_busy_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    devBusy |-> !(strb.act || strb.rd || strb.wr || strb.pre || strb.loadRfsh || strb.loadMrs));

  // R8: refresh and mode set are only accepted with every bank idle
  assert_dev_cmd_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.loadRfsh || strb.loadMrs) |-> (&idleVec));

endmodule

// File: rtl/sdram_chk_ctrl.sv
module sdram_chk_ctrl
  import sdram_chk_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  localparam int BAW      = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cke,
  input  logic                 csN,
  input  logic                 rasN,
  input  logic                 casN,
  input  logic                 weN,
  input  logic [BAW-1:0]       ba,
  input  logic                 a10,
  input  logic [NUM_BANKS-1:0] idleVec,
  input  logic [NUM_BANKS-1:0] actgVec,
  input  logic [NUM_BANKS-1:0] prechVec,
  input  logic [NUM_BANKS-1:0] wrecVec,
  input  logic [NUM_BANKS-1:0] apVec,
  input  logic [NUM_BANKS-1:0] rasPendVec,
  input  logic                 rrdBusy,
  input  logic                 devBusy,
  output chkStrobe_t           strb,
  output logic [NUM_BANKS-1:0] bankSel,
  output logic                 errPulse,
  output logic [3:0]           errCode
);

  logic                 ckePrev;
  busCmd_t              cmd;
  logic                 isNop, isRdWr, live;
  logic [NUM_BANKS-1:0] bankOh, preMask;
  chkErr_t              codeNow;

  assign cmd     = csN ? CMD_NOP : busCmd_t'({rasN, casN, weN});
  assign isNop   = (cmd == CMD_NOP);
  assign isRdWr  = (cmd == CMD_RD) || (cmd == CMD_WR);
  assign live    = ckePrev;
  assign bankOh  = NUM_BANKS'(1) << ba;
  assign preMask = a10 ? '1 : bankOh;

  always_comb begin
    codeNow = ERR_NONE;
    if (!ckePrev && cke && !isNop)
      codeNow = ERR_PD_EXIT;
    else if (live && devBusy && !isNop)
      codeNow = ERR_DEV_BUSY;
    else if (live && (cmd == CMD_MRS || cmd == CMD_REF || !cke) && !(&idleVec))
      codeNow = ERR_NOT_IDLE;
    else if (live && isRdWr && |(bankOh & (idleVec | prechVec)))
      codeNow = ERR_NO_ROW;
    else if (live && cmd == CMD_ACT && |(bankOh & ~idleVec & ~prechVec))
      codeNow = ERR_ROW_OPEN;
    else if (live && cmd == CMD_ACT && |(bankOh & prechVec))
      codeNow = ERR_TRP;
    else if (live && isRdWr && |(bankOh & actgVec))
      codeNow = ERR_TRCD;
    else if (live && cmd == CMD_PRE && |(preMask & rasPendVec))
      codeNow = ERR_TRAS;
    else if (live && cmd == CMD_ACT && rrdBusy)
      codeNow = ERR_TRRD;
    else if (live && ((isRdWr && |(bankOh & apVec)) || (cmd == CMD_PRE && |(preMask & apVec))))
      codeNow = ERR_AP_LOCK;
    else if (live && cmd == CMD_PRE && |(preMask & wrecVec & ~apVec))
      codeNow = ERR_TDPL;
  end

  logic go;
  assign go = live && (codeNow == ERR_NONE);

  always_comb begin
    strb          = '0;
    strb.act      = go && (cmd == CMD_ACT);
    strb.rd       = go && (cmd == CMD_RD);
    strb.wr       = go && (cmd == CMD_WR);
    strb.pre      = go && (cmd == CMD_PRE);
    strb.autoPre  = a10;
    strb.loadRfsh = go && (cmd == CMD_REF);
    strb.loadMrs  = go && (cmd == CMD_MRS);
    bankSel       = (cmd == CMD_PRE) ? preMask : bankOh;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ckePrev  <= 1'b1;
      errPulse <= 1'b0;
      errCode  <= 4'd0;
    end else begin
      ckePrev  <= cke;
      errPulse <= (codeNow != ERR_NONE);
      errCode  <= codeNow;
    end
  end

  // R12: while the clock enable stays low, nothing reaches the bank model
  assert_low_power_quiet_R12: assert property (@(posedge clk) disable iff (!rstN)
    (!ckePrev && !cke) |-> !(strb.act || strb.rd || strb.wr || strb.pre || strb.loadRfsh || strb.loadMrs));

  // R2: a flagged edge is followed by a clean one unless the next command also fails
  assert_pulse_one_cycle_R2: assert property (@(posedge clk) disable iff (!rstN)
    (codeNow == ERR_NONE) |=> !errPulse);

endmodule

// File: rtl/sdram_chk.sv
module sdram_chk
  import sdram_chk_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int T_RCD     = 3,
  parameter int T_RAS     = 7,
  parameter int T_RP      = 3,
  parameter int T_RRD     = 2,
  parameter int T_RC      = 9,
  parameter int T_MRD     = 2,
  parameter int T_DPL     = 2,
  parameter int BURST_LEN = 4,
  localparam int BAW      = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           cke,
  input  logic           csN,
  input  logic           rasN,
  input  logic           casN,
  input  logic           weN,
  input  logic [BAW-1:0] ba,
  input  logic           a10,
  output logic           errPulse,
  output logic [3:0]     errCode
);

  chkStrobe_t           strb;
  logic [NUM_BANKS-1:0] bankSel;
  logic [NUM_BANKS-1:0] idleVec, actgVec, prechVec, wrecVec, apVec, rasPendVec;
  logic                 rrdBusy, devBusy;

  sdram_chk_ctrl #(.NUM_BANKS(NUM_BANKS)) u_ctrl (
    .clk(clk), .rstN(rstN), .cke(cke), .csN(csN), .rasN(rasN), .casN(casN),
    .weN(weN), .ba(ba), .a10(a10),
    .idleVec(idleVec), .actgVec(actgVec), .prechVec(prechVec), .wrecVec(wrecVec),
    .apVec(apVec), .rasPendVec(rasPendVec), .rrdBusy(rrdBusy), .devBusy(devBusy),
    .strb(strb), .bankSel(bankSel), .errPulse(errPulse), .errCode(errCode)
  );

  sdram_chk_banks #(
    .NUM_BANKS(NUM_BANKS), .T_RCD(T_RCD), .T_RAS(T_RAS), .T_RP(T_RP),
    .T_RRD(T_RRD), .T_RC(T_RC), .T_MRD(T_MRD), .T_DPL(T_DPL), .BURST_LEN(BURST_LEN)
  ) u_banks (
    .clk(clk), .rstN(rstN), .strb(strb), .bankSel(bankSel),
    .idleVec(idleVec), .actgVec(actgVec), .prechVec(prechVec), .wrecVec(wrecVec),
    .apVec(apVec), .rasPendVec(rasPendVec), .rrdBusy(rrdBusy), .devBusy(devBusy)
  );

endmodule

// File: tb/sdram_chk_bench.sv
`timescale 1ns/1ps
module sdram_chk_bench;

  localparam logic [2:0] C_MRS = 3'b000, C_REF = 3'b001, C_PRE = 3'b010, C_ACT = 3'b011,
                         C_WR  = 3'b100, C_RD  = 3'b101, C_NOP = 3'b111;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cke = 1'b1, csN = 1'b1, a10 = 1'b0;
  logic [2:0] cmdBits = C_NOP;
  logic [1:0] ba = 2'd0;
  logic       errPulse;
  logic [3:0] errCode;

  int nCmp = 0, nBad = 0;
  int expQ[$];
  string tagQ[$];
  bit done = 1'b0;

  always #2 clk = ~clk;

  sdram_chk #(
    .NUM_BANKS(4), .T_RCD(3), .T_RAS(5), .T_RP(2), .T_RRD(2),
    .T_RC(6), .T_MRD(2), .T_DPL(2), .BURST_LEN(2)
  ) u_sdram_chk (
    .clk(clk), .rstN(rstN), .cke(cke), .csN(csN),
    .rasN(cmdBits[2]), .casN(cmdBits[1]), .weN(cmdBits[0]),
    .ba(ba), .a10(a10), .errPulse(errPulse), .errCode(errCode)
  );

  task automatic compare(input int exp, input string tag);
    nCmp++;
    if (errPulse !== (exp != 0) || errCode !== 4'(exp)) begin
      nBad++;
      $display("FAIL %s: errPulse=%0b errCode=%0d, expected errPulse=%0b errCode=%0d",
               tag, errPulse, errCode, (exp != 0), exp);
    end
  endtask

  // Driver: one bus command per cycle, expected code queued for the monitor
  task automatic step(input logic ck, input logic cs, input logic [2:0] c,
                      input int b, input logic ap, input int exp, input string tag);
    @(negedge clk);
    cke = ck; csN = cs; cmdBits = c; ba = 2'(b); a10 = ap;
    expQ.push_back(exp);
    tagQ.push_back(tag);
  endtask

  task automatic cmd(input logic [2:0] c, input int b, input logic ap,
                     input int exp, input string tag);
    step(1'b1, 1'b0, c, b, ap, exp, tag);
  endtask

  // Monitor: output registered at the edge, read just after it
  always @(posedge clk) begin
    #1;
    if (expQ.size() != 0) compare(expQ.pop_front(), tagQ.pop_front());
  end

  initial begin
    #20000;
    if (!done) begin
      nBad++;
      $display("FAIL watchdog: run did not complete, actual hung, expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    compare(0, "R1 in reset");
    rstN = 1'b1;
    @(negedge clk);
    compare(0, "R1 after reset");

    cmd(C_ACT, 0, 0, 0,  "R2 activate b0");
    cmd(C_ACT, 1, 0, 9,  "R7 activate b1 inside tRRD");
    cmd(C_RD,  0, 0, 7,  "R5 read b0 inside tRCD");
    cmd(C_RD,  0, 0, 0,  "R5 read b0 at tRCD");
    cmd(C_PRE, 0, 0, 8,  "R6 precharge b0 inside tRAS");
    cmd(C_PRE, 0, 0, 0,  "R6 precharge b0 at tRAS");
    cmd(C_ACT, 0, 0, 6,  "R4 activate b0 inside tRP");
    cmd(C_ACT, 0, 0, 0,  "R13 rejected activate left b0 precharged, R4 at tRP");
    cmd(C_RD,  2, 0, 4,  "R3 read of idle b2");
    cmd(C_ACT, 1, 0, 0,  "R7 activate b1 at tRRD");
    cmd(C_ACT, 1, 0, 5,  "R13 smallest code: open row beats tRRD, R4");
    cmd(C_NOP, 0, 0, 0,  "R2 nop");
    cmd(C_WR,  1, 1, 0,  "R10 write b1 with auto-precharge");
    cmd(C_RD,  1, 0, 10, "R10 read b1 during auto-precharge burst");
    cmd(C_PRE, 1, 0, 10, "R10 precharge b1 during auto-precharge recovery");
    cmd(C_MRS, 0, 0, 3,  "R8 mode set with b0 open");
    cmd(C_PRE, 0, 1, 0,  "R10 R6 precharge all after self-timed b1 precharge");
    cmd(C_NOP, 0, 0, 0,  "R2 nop");
    cmd(C_REF, 0, 0, 0,  "R8 refresh with all idle");
    cmd(C_RD,  0, 0, 2,  "R9 R13 read during refresh window");
    step(1'b1, 1'b1, C_RD, 0, 0, 0, "R9 deselect during refresh window");
    cmd(C_NOP, 0, 0, 0,  "R9 nop during refresh window");
    cmd(C_NOP, 0, 0, 0,  "R9 nop during refresh window");
    cmd(C_ACT, 3, 0, 2,  "R9 activate one cycle before tRC");
    cmd(C_ACT, 3, 0, 0,  "R9 activate at tRC");
    cmd(C_PRE, 3, 0, 8,  "R6 precharge b3 inside tRAS");
    cmd(C_NOP, 0, 0, 0,  "R2 nop");
    cmd(C_WR,  3, 0, 0,  "R11 write b3");
    cmd(C_NOP, 0, 0, 0,  "R11 write burst");
    cmd(C_PRE, 3, 0, 11, "R11 precharge b3 during write recovery");
    cmd(C_PRE, 3, 0, 0,  "R11 precharge b3 after recovery");
    cmd(C_NOP, 0, 0, 0,  "R2 nop");
    step(1'b0, 1'b0, C_NOP, 0, 0, 0, "R8 power-down entry all idle");
    step(1'b0, 1'b0, C_ACT, 0, 0, 0, "R12 activate ignored while clock enable low");
    step(1'b1, 1'b0, C_RD,  0, 0, 1, "R12 read on power-down exit edge");
    cmd(C_MRS, 0, 0, 0,  "R12 R8 mode set: ignored activate left banks idle");
    cmd(C_ACT, 2, 0, 2,  "R9 activate inside mode-set window");
    cmd(C_ACT, 2, 0, 0,  "R9 activate after mode-set window");
    step(1'b0, 1'b0, C_NOP, 0, 0, 3, "R8 clock-enable drop with b2 open");
    step(1'b1, 1'b0, C_NOP, 0, 0, 0, "R12 nop on exit edge");
    cmd(C_PRE, 0, 0, 0,  "R6 precharge of idle b0");
    cmd(C_RD,  0, 0, 4,  "R6 idle precharge had no effect, R3");
    cmd(C_NOP, 0, 0, 0,  "R2 nop");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

endmodule